// File: doc/BRIEF.md
# Field Memory Initialization Sequencer

This block sits on the host side of a serial field memory. It drives the memory's two control groups. The write side has a serial clock qualifier, a pointer reset, a write enable and an input enable. The read side has a serial clock qualifier, a pointer reset, a read enable and an output enable. The block paces these so that the memory's start-up and access rules are never broken.

After reset the block stays quiet for a settling wait, which stands in for the power-stabilization interval. It then runs dummy serial clock cycles on both ports. Next it issues a pointer reset on both ports, with a guard of enable-low clock cycles before and after it, and then raises `ready`.

From then on, each frame request starts the same guarded reset. A burst follows with all four enables high. The burst never runs shorter than the memory's minimum active length. If the host aborts a burst before that minimum is reached, a sticky error flag is raised. The flag stays set until the next pointer reset.

A clock-qualifier output high means that one serial clock cycle is issued to the memory in that cycle of `clk`.

Top module: `fmis_init_seq`

## Requirements
- R1: While `rst` is high, and for `PWR_WAIT_CYC` cycles counted from the cycle in which `rst` is released, every memory pin output is low. During that time `ready` and `err` are low as well.
- R2: After the wait, `wck_en` and `rck_en` are high together for exactly `DUMMY_CYC` dummy cycles. During these cycles `we`, `ie`, `re` and `oe` are low. The write and read clock qualifiers are always equal.
- R3: Every pointer reset has `GUARD_CYC` cycles before it and `GUARD_CYC` cycles after it. In these guard cycles both clock qualifiers are high and all four enables are low. At start-up, the pre-reset guard follows the dummy cycles directly, so the block runs `DUMMY_CYC + GUARD_CYC` clocked, enable-low cycles before the first reset.
- R4: A pointer reset is `wrst` and `rrst` high together for exactly one cycle. Both clock qualifiers are high in that cycle and all enables are low.
- R5: `ready` first rises in the cycle after the post-reset guard of the start-up reset. While `ready` is high, the block issues no clock cycles, no enables and no resets.
- R6: `frame_req` has no effect while `ready` is low. This holds both during start-up and during a burst: no extra reset and no extra burst results.
- R7: A frame request taken while `ready` is high produces the guarded reset of R3 and R4. A burst follows directly. In every burst cycle `we`, `ie`, `re`, `oe`, `wck_en` and `rck_en` are all high. The burst lasts max(`frame_len`, `MIN_ACTIVE`) cycles, and then `ready` returns.
- R8: `abort` high in a burst cycle makes that cycle the last active one. If fewer than `MIN_ACTIVE` active cycles were issued at that point, `err` rises in the next cycle. `err` then holds until the cycle after the next pointer reset, where it clears. An abort at or beyond `MIN_ACTIVE` active cycles leaves `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | Start a guarded reset plus burst; sampled only while `ready` is high |
| frame_len | input | LEN_W | Requested burst length in cycles, raised to `MIN_ACTIVE` if shorter |
| abort | input | 1 | End the current burst after this cycle |
| ready | output | 1 | Idle and initialized; a request may be given |
| err | output | 1 | Sticky flag for a burst aborted short of the minimum |
| wck_en | output | 1 | Issue one write serial clock cycle |
| wrst | output | 1 | Write pointer reset |
| we | output | 1 | Write enable |
| ie | output | 1 | Input enable |
| rck_en | output | 1 | Issue one read serial clock cycle |
| rrst | output | 1 | Read pointer reset |
| re | output | 1 | Read enable |
| oe | output | 1 | Output enable |

## Verification
The bench measures each start-up phase length to the exact cycle. A timer loaded off by one would show up as a wait, dummy run or guard that is one cycle long or short. It sweeps burst lengths below, at and above the minimum. A design that drops the clamp would issue a five-cycle burst, and one that mis-compares would stop one cycle early or late. Aborts before and exactly at the minimum are tested. A wrong threshold would raise the error flag on a legal abort, or miss a real one. A flag that does not stick, or that clears at the wrong point, would be seen low before the next reset or still high after it. Requests given during the wait and in mid-burst are checked for stray resets, which a design that decodes the request outside idle would produce.

// File: rtl/fmis_pkg.sv
package fmis_pkg;

    typedef enum logic [2:0] {
        WAIT_PWR       = 3'd0,
        DUMMY          = 3'd1,
        RST_GUARD_PRE  = 3'd2,
        RESET          = 3'd3,
        RST_GUARD_POST = 3'd4,
        READY          = 3'd5,
        BURST          = 3'd6
    } fmis_state_e;

    typedef struct packed {
        logic wck;
        logic wrst;
        logic we;
        logic ie;
        logic rck;
        logic rrst;
        logic re;
        logic oe;
    } fmis_pins_t;

    localparam fmis_pins_t PINS_OFF = '0;

    function automatic int unsigned fmis_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned fmis_bits(input int unsigned v);
        int unsigned n;
        n = 1;
        while ((64'd1 << n) <= 64'(v)) n++;
        return n;
    endfunction

endpackage

// File: rtl/fmis_timer.sv
module fmis_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fmis_burst.sv
module fmis_burst #(
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned MIN_ACTIVE = 231
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             abort,
    output logic             last,
    output logic             short_abort
);
    localparam logic [LEN_W:0] MIN_V = (LEN_W+1)'(MIN_ACTIVE);

    logic [LEN_W:0] target_q;
    logic [LEN_W:0] done_q;
    logic [LEN_W:0] done_next;
    logic [LEN_W:0] len_ext;

    assign len_ext   = {1'b0, frame_len};
    assign done_next = done_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= MIN_V;
            done_q   <= '0;
        end else if (start) begin
            target_q <= (len_ext < MIN_V) ? MIN_V : len_ext;
            done_q   <= '0;
        end else if (active) begin
            done_q   <= done_next;
        end
    end

    assign last        = active && (abort || (done_next >= target_q));
    assign short_abort = active && abort && (done_next < MIN_V);
endmodule

// File: rtl/fmis_pin_map.sv
module fmis_pin_map
    import fmis_pkg::*;
(
    input  fmis_state_e state,
    output fmis_pins_t  pins
);
    always_comb begin
        pins = PINS_OFF;
        unique case (state)
            DUMMY, RST_GUARD_PRE, RST_GUARD_POST: begin
                pins.wck = 1'b1;
                pins.rck = 1'b1;
            end
            RESET: begin
                pins.wck  = 1'b1;
                pins.rck  = 1'b1;
                pins.wrst = 1'b1;
                pins.rrst = 1'b1;
            end
            BURST: begin
                pins.wck = 1'b1;
                pins.rck = 1'b1;
                pins.we  = 1'b1;
                pins.ie  = 1'b1;
                pins.re  = 1'b1;
                pins.oe  = 1'b1;
            end
            default: pins = PINS_OFF;
        endcase
    end
endmodule

// File: rtl/fmis_init_seq.sv
module fmis_init_seq
    import fmis_pkg::*;
#(
    parameter int unsigned PWR_WAIT_CYC = 10000,
    parameter int unsigned DUMMY_CYC    = 150,
    parameter int unsigned GUARD_CYC    = 2,
    parameter int unsigned MIN_ACTIVE   = 231,
    parameter int unsigned LEN_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_req,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             abort,
    output logic             ready,
    output logic             err,
    output logic             wck_en,
    output logic             wrst,
    output logic             we,
    output logic             ie,
    output logic             rck_en,
    output logic             rrst,
    output logic             re,
    output logic             oe
);
    localparam int unsigned LONGEST = fmis_max(fmis_max(PWR_WAIT_CYC, DUMMY_CYC), GUARD_CYC);
    localparam int unsigned TMR_W   = fmis_bits(LONGEST);
    localparam logic [TMR_W-1:0] DUMMY_LD = TMR_W'(DUMMY_CYC - 1);
    localparam logic [TMR_W-1:0] GUARD_LD = TMR_W'(GUARD_CYC - 1);

    fmis_state_e state_q, state_d;
    logic        init_done_q;
    logic        pending_q;
    logic        err_q;
    logic        tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic        tmr_expired;
    logic        accept;
    logic        burst_last;
    logic        burst_short;
    fmis_pins_t  pins;

    assign ready  = init_done_q && (state_q == READY);
    assign accept = ready && frame_req;

    fmis_timer #(
        .W       (TMR_W),
        .RST_VAL (PWR_WAIT_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fmis_burst #(
        .LEN_W      (LEN_W),
        .MIN_ACTIVE (MIN_ACTIVE)
    ) u_burst (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .active      (state_q == BURST),
        .frame_len   (frame_len),
        .abort       (abort),
        .last        (burst_last),
        .short_abort (burst_short)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = GUARD_LD;
        unique case (state_q)
            WAIT_PWR: begin
                if (tmr_expired) begin
                    state_d  = DUMMY;
                    tmr_load = 1'b1;
                    tmr_val  = DUMMY_LD;
                end
            end
            DUMMY: begin
                if (tmr_expired) begin
                    state_d  = RST_GUARD_PRE;
                    tmr_load = 1'b1;
                end
            end
            RST_GUARD_PRE: begin
                if (tmr_expired) state_d = RESET;
            end
            RESET: begin
                state_d  = RST_GUARD_POST;
                tmr_load = 1'b1;
            end
            RST_GUARD_POST: begin
                if (tmr_expired) state_d = pending_q ? BURST : READY;
            end
            READY: begin
                if (accept) begin
                    state_d  = RST_GUARD_PRE;
                    tmr_load = 1'b1;
                end
            end
            BURST: begin
                if (burst_last) state_d = READY;
            end
            default: state_d = WAIT_PWR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= WAIT_PWR;
            init_done_q <= 1'b0;
            pending_q   <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == RST_GUARD_POST && state_d == READY)
                init_done_q <= 1'b1;
            if (accept)
                pending_q <= 1'b1;
            else if (state_q == BURST && burst_last)
                pending_q <= 1'b0;
            if (state_q == RESET)
                err_q <= 1'b0;
            else if (burst_short)
                err_q <= 1'b1;
        end
    end

    fmis_pin_map u_pins (
        .state (state_q),
        .pins  (pins)
    );

    assign err    = err_q;
    assign wck_en = pins.wck;
    assign wrst   = pins.wrst;
    assign we     = pins.we;
    assign ie     = pins.ie;
    assign rck_en = pins.rck;
    assign rrst   = pins.rrst;
    assign re     = pins.re;
    assign oe     = pins.oe;
endmodule

// File: rtl/fmis_checker.sv
module fmis_checker #(
    parameter int unsigned MIN_ACTIVE = 231,
    parameter int unsigned GUARD_CYC  = 2
) (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic err,
    input logic wck_en,
    input logic wrst,
    input logic we,
    input logic ie,
    input logic rck_en,
    input logic rrst,
    input logic re,
    input logic oe
);
    int unsigned pre_low;
    int unsigned since_rst;
    int unsigned run;
    logic        rst_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_low   <= 0;
            since_rst <= 0;
            run       <= 0;
            rst_seen  <= 1'b0;
        end else begin
            if (wck_en && !we && !re) begin
                if (pre_low != 32'hFFFF_FFFF) pre_low <= pre_low + 1;
            end else begin
                pre_low <= 0;
            end
            if (wrst) since_rst <= 0;
            else if (!we && since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1;
            if (we) run <= run + 1;
            else    run <= 0;
            if (wrst) rst_seen <= 1'b1;
        end
    end

    a_r2_clock_pair: assert property (@(posedge clk) disable iff (rst)
        wck_en == rck_en);

    a_r4_reset_pair: assert property (@(posedge clk) disable iff (rst)
        wrst == rrst);

    a_r4_reset_single: assert property (@(posedge clk) disable iff (rst)
        wrst |=> !wrst);

    a_r3_guard_before: assert property (@(posedge clk) disable iff (rst)
        wrst |-> (pre_low >= GUARD_CYC) && !we && !re);

    a_r3_guard_after: assert property (@(posedge clk) disable iff (rst)
        $rose(we) |-> (since_rst >= GUARD_CYC) && rst_seen);

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ready |-> !wck_en && !rck_en && !we && !re && !wrst);

    a_r5_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        ready |-> rst_seen);

    a_r7_burst_pins: assert property (@(posedge clk) disable iff (rst)
        we |-> ie && re && oe && wck_en && rck_en && !wrst);

    a_r7_min_burst: assert property (@(posedge clk) disable iff (rst)
        $fell(we) |-> err || (run >= MIN_ACTIVE));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err && !wrst |=> err);
endmodule

bind fmis_init_seq fmis_checker #(
    .MIN_ACTIVE (MIN_ACTIVE),
    .GUARD_CYC  (GUARD_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ready  (ready),
    .err    (err),
    .wck_en (wck_en),
    .wrst   (wrst),
    .we     (we),
    .ie     (ie),
    .rck_en (rck_en),
    .rrst   (rrst),
    .re     (re),
    .oe     (oe)
);

// File: tb/fmis_init_seq_test.sv
module fmis_init_seq_test;
    localparam int PWR  = 40;
    localparam int DUM  = 150;
    localparam int GRD  = 2;
    localparam int MINA = 231;
    localparam int LW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_req = 1'b0;
    logic [LW-1:0] frame_len = '0;
    logic          abort = 1'b0;
    logic ready, err, wck_en, wrst, we, ie, rck_en, rrst, re, oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fmis_init_seq #(
        .PWR_WAIT_CYC (PWR),
        .DUMMY_CYC    (DUM),
        .GUARD_CYC    (GRD),
        .MIN_ACTIVE   (MINA),
        .LEN_W        (LW)
    ) uut (
        .clk(clk), .rst(rst), .frame_req(frame_req), .frame_len(frame_len),
        .abort(abort), .ready(ready), .err(err), .wck_en(wck_en), .wrst(wrst),
        .we(we), .ie(ie), .rck_en(rck_en), .rrst(rrst), .re(re), .oe(oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pins_word();
        return {wck_en, wrst, we, ie, rck_en, rrst, re, oe};
    endfunction

    task automatic t_reset_state();
        repeat (4) @(negedge clk);
        chk(pins_word() == 0 && !ready && !err, "R1", "pins during reset",
            pins_word(), 0);
    endtask

    task automatic t_init();
        int idx = 0;
        int d, rc, post;
        bit bad = 0;
        rst = 1'b0;
        // a request given during the wait must change nothing (R6)
        while (!wck_en && idx < 10 * PWR) begin
            @(negedge clk);
            idx++;
            frame_req = (idx == 3);
            if (ready || we || re || wrst) bad = 1;
        end
        frame_req = 1'b0;
        chk(idx == PWR, "R1", "quiet cycles after reset release", idx, PWR);
        chk(!bad, "R6", "no activity from request during wait", bad, 0);
        d = 1;
        bad = 0;
        forever begin
            @(negedge clk);
            if (!wck_en || wrst || we) break;
            if (rck_en != wck_en || ie || re || oe) bad = 1;
            d++;
        end
        chk(d == DUM + GRD, "R2", "dummy plus pre-guard clocked cycles", d, DUM + GRD);
        chk(!bad, "R2", "enables low and clocks paired in dummy run", bad, 0);
        rc = 0;
        bad = 0;
        while (wrst) begin
            if (!rrst || !wck_en || we || re) bad = 1;
            rc++;
            @(negedge clk);
        end
        chk(rc == 1, "R4", "start-up reset pulse length", rc, 1);
        chk(!bad, "R4", "reset pair with clock and enables low", bad, 0);
        post = 0;
        bad = 0;
        while (!ready && post < 100) begin
            if (!wck_en || we || re) bad = 1;
            post++;
            @(negedge clk);
        end
        chk(post == GRD && !bad, "R3", "post-reset guard cycles", post, GRD);
        bad = 0;
        repeat (5) begin
            if (!ready || pins_word() != 0) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R5", "ready idle with pins quiet", bad, 0);
    endtask

    task automatic run_frame(input int len, input int abort_at, input int poke_at,
                             output int pre, output int rc, output int post,
                             output int act, output bit e_rst, output bit e_post,
                             output bit e_end, output bit pin_bad);
        int n = 0;
        pre = 0; rc = 0; post = 0; act = 0;
        e_rst = 0; e_post = 0; e_end = 0; pin_bad = 0;
        frame_len = LW'(len);
        frame_req = 1'b1;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            frame_req = 1'b0;
            abort = 1'b0;
            if (ready) begin
                e_end = err;
                break;
            end
            if (we) begin
                act++;
                if (!(ie && re && oe && wck_en && rck_en) || wrst) pin_bad = 1;
                if (act == abort_at) abort = 1'b1;
                if (act == poke_at) frame_req = 1'b1;
            end else if (wrst) begin
                rc++;
                e_rst = err;
                if (!rrst || !wck_en) pin_bad = 1;
            end else if (rc == 0) begin
                pre++;
                if (!wck_en || ie || oe) pin_bad = 1;
            end else begin
                post++;
                if (post == 1) e_post = err;
                if (!wck_en || ie || oe) pin_bad = 1;
            end
        end
    endtask

    task automatic t_frame_len(input int len, input int exp_len);
        int pre, rc, post, act;
        bit e_rst, e_post, e_end, pb;
        run_frame(len, 0, 0, pre, rc, post, act, e_rst, e_post, e_end, pb);
        chk(pre == GRD && post == GRD, "R3", "frame guards pre/post", pre * 100 + post,
            GRD * 100 + GRD);
        chk(rc == 1, "R4", "frame reset pulse", rc, 1);
        chk(act == exp_len && !pb, "R7", $sformatf("burst length for len %0d", len),
            act, exp_len);
    endtask

    task automatic t_poke_ignored();
        int pre, rc, post, act;
        bit e_rst, e_post, e_end, pb;
        bit bad = 0;
        run_frame(5, 0, 5, pre, rc, post, act, e_rst, e_post, e_end, pb);
        chk(act == MINA, "R7", "short request clamped to minimum", act, MINA);
        repeat (10) begin
            if (!ready || wrst || wck_en) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R6", "request during burst ignored", bad, 0);
    endtask

    task automatic t_abort_short();
        int pre, rc, post, act;
        bit e_rst, e_post, e_end, pb;
        run_frame(300, 100, 0, pre, rc, post, act, e_rst, e_post, e_end, pb);
        chk(act == 100, "R8", "aborted burst length", act, 100);
        chk(e_end == 1, "R8", "err after short abort", e_end, 1);
        repeat (7) @(negedge clk);
        chk(err == 1 && ready, "R8", "err holds while idle", err, 1);
        run_frame(240, 0, 0, pre, rc, post, act, e_rst, e_post, e_end, pb);
        chk(e_rst == 1, "R8", "err still set in reset cycle", e_rst, 1);
        chk(e_post == 0, "R8", "err cleared after reset", e_post, 0);
        chk(act == 240 && e_end == 0, "R7", "burst after clear", act, 240);
    endtask

    task automatic t_abort_at_min();
        int pre, rc, post, act;
        bit e_rst, e_post, e_end, pb;
        run_frame(300, MINA, 0, pre, rc, post, act, e_rst, e_post, e_end, pb);
        chk(act == MINA, "R8", "abort at minimum length", act, MINA);
        chk(e_end == 0, "R8", "no err for abort at minimum", e_end, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_init();
        t_frame_len(300, 300);
        t_frame_len(0, MINA);
        t_frame_len(MINA, MINA);
        t_frame_len(MINA + 1, MINA + 1);
        t_poke_ignored();
        t_abort_short();
        t_abort_at_min();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule